// File: doc/BRIEF.md
# Real-Time Debug Halt Controller

This block sits beside a processor core and decides, cycle by cycle, whether the core runs freely, is stopped for debug, or executes exactly one instruction under host control. It watches three kinds of break event: a decoded software breakpoint, a hardware watch/break comparator hit, and a halt request from the host. It also honours a debug mask bit that fences off regions of code where halts and debugger accesses are forbidden. A software breakpoint replaces a real instruction, so it always halts at once. The other two kinds are deferrable: they wait in a pending latch until the debug mask drops.

The block also arbitrates interrupts. While the core runs, an interrupt needs its enable bit and a clear global interrupt mask. While the core is stopped for debug, the global mask is ignored, and an interrupt is time-critical only when it is enabled in both the normal enable register and a second, debug-specific enable register. When both the global mask and the debug mask are set, nothing gets through.

The chosen interrupt leaves on a valid/ready acknowledge channel. Once `ack_valid_o` rises, the one-hot vector and the index stay frozen until the cycle in which `ack_ready_i` is sampled high. The next interrupt can be captured no earlier than the following cycle. The consumer may hold `ack_ready_i` low for any number of cycles, and nothing is lost meanwhile, because the raised flags stay stored.

Top module: `rtdbg_ctrl`

## Requirements
- R1: After reset the state is run (`state_o` = 0), `halt_o` and `ack_valid_o` are low, no halt is pending and no interrupt flag is stored.
- R2: `state_o` encodes run as 0, debug halt as 1 and single-step as 2, and `halt_o` is high exactly in debug halt. In run state with the debug mask clear, a watch hit or host halt request moves the state to debug halt at the next clock edge.
- R3: A software breakpoint in run state enters debug halt at the next clock edge even when the debug mask is set.
- R4: A watch hit or host halt request that arrives while the debug mask is set leaves the core in run state and stays pending. Halt is entered at the first clock edge at which the mask is seen clear.
- R5: A software breakpoint and a deferrable request in the same cycle cause one halt entry. Entering halt clears the pending latch, so after the return to run no second halt follows.
- R6: From debug halt, a host step pulse moves to single-step, and one instruction-done pulse there returns to debug halt. A host run pulse returns to run state. If run and step arrive together, run wins.
- R7: In run and single-step states, a stored interrupt is eligible when its enable bit is set and the global mask is clear. While the mask is set, the interrupt stays stored and is taken after the mask clears.
- R8: In debug halt, a stored interrupt is eligible when it is set in both the enable and the debug enable registers, whatever the global mask says.
- R9: While the global mask and the debug mask are both set, no interrupt is captured and no debug access is granted.
- R10: `dbg_acc_gnt_o` is high in the same cycle as `dbg_acc_req_i` whenever the debug mask is clear, and it is low whenever the mask is set.
- R11: Among eligible interrupts, the lowest index is captured. Its stored flag is cleared on capture, so it is acknowledged only once per raise.
- R12: While `ack_valid_o` is high and `ack_ready_i` is low, valid, index and one-hot vector hold steady. The handshake completes at the edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swbp_i | input | 1 | Software breakpoint decoded this cycle |
| wp_hit_i | input | 1 | Hardware watch/break comparator hit |
| host_halt_i | input | 1 | Host halt request pulse |
| host_run_i | input | 1 | Host run command pulse |
| host_step_i | input | 1 | Host single-step command pulse |
| instr_done_i | input | 1 | Instruction completed pulse from the core |
| intm_i | input | 1 | Global interrupt mask (1 = masked) |
| dbgm_i | input | 1 | Debug mask (1 = no halt, no debug access) |
| ier_i | input | NIRQ | Interrupt enable register |
| dbgier_i | input | NIRQ | Debug interrupt enable register |
| irq_raise_i | input | NIRQ | Interrupt raise pulses, stored as flags |
| dbg_acc_req_i | input | 1 | Debugger register/memory access request |
| dbg_acc_gnt_o | output | 1 | Debugger access grant |
| state_o | output | 2 | Current state (0 run, 1 halt, 2 step) |
| halt_o | output | 1 | High in debug halt |
| ack_valid_o | output | 1 | Interrupt acknowledge valid |
| ack_ready_i | input | 1 | Interrupt acknowledge accepted |
| ack_onehot_o | output | NIRQ | One-hot acknowledged interrupt |
| ack_idx_o | output | IDXW | Index of acknowledged interrupt |

## Verification
The embedded properties check on every cycle that a software breakpoint in run state always reaches halt, and that the debug mask keeps the core in run when no breakpoint is present. They also check that a step completion returns to halt, that the pending latch is empty after each halt entry, that a stalled acknowledge stays frozen and one-hot, and that nothing is captured under the double mask. Only the bench scenarios can show the longer orderings. These are a deferred request that fires once the mask falls, a shared halt entry with no second halt after resuming, priority between several flags, and flags that survive a masked window and are taken later in a different state with the correct enable register applied.

// File: rtl/rtdbg_pkg.sv
package rtdbg_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } dbg_state_e;
endpackage

// File: rtl/rtdbg_halt_pend.sv
module rtdbg_halt_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic swbp,
  input  logic wp_hit,
  input  logic host_halt,
  input  logic dbgm,
  output logic enter_halt,
  output logic pend_q
);
  logic defer_req;

  assign defer_req  = pend_q | wp_hit | host_halt;
  assign enter_halt = in_run & (swbp | (defer_req & ~dbgm));

  always_ff @(posedge clk) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (enter_halt) pend_q <= 1'b0;
    else if (in_run)     pend_q <= defer_req;
    else                 pend_q <= 1'b0;
  end

  // R5
  pend_clear_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_halt |=> !pend_q);
endmodule

// File: rtl/rtdbg_fsm.sv
module rtdbg_fsm
  import rtdbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_halt,
  input  logic       host_run,
  input  logic       host_step,
  input  logic       instr_done,
  output dbg_state_e state_q
);
  dbg_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (enter_halt) state_d = ST_HALT;
      ST_HALT: begin
        if (host_run)       state_d = ST_RUN;
        else if (host_step) state_d = ST_STEP;
      end
      ST_STEP: if (instr_done) state_d = ST_HALT;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // R6
  step_returns_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP && instr_done) |=> state_q == ST_HALT);
  // R6
  halt_run_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && host_run) |=> state_q == ST_RUN);
endmodule

// File: rtl/rtdbg_irq_arb.sv
module rtdbg_irq_arb #(
  parameter int NIRQ = 16,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halted,
  input  logic            intm,
  input  logic            dbgm,
  input  logic [NIRQ-1:0] ier,
  input  logic [NIRQ-1:0] dbgier,
  input  logic [NIRQ-1:0] irq_raise,
  input  logic            ack_ready,
  output logic            ack_valid,
  output logic [NIRQ-1:0] ack_onehot,
  output logic [IDXW-1:0] ack_idx
);
  logic [NIRQ-1:0] flag_q;
  logic [NIRQ-1:0] gate;
  logic [NIRQ-1:0] elig;
  logic [NIRQ-1:0] pick_oh;
  logic [IDXW-1:0] pick_idx;
  logic            found;
  logic            capture;

  always_comb begin
    if (intm && dbgm) gate = '0;
    else if (halted)  gate = dbgier;
    else if (intm)    gate = '0;
    else              gate = '1;
  end

  assign elig = flag_q & ier & gate;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found    = 1'b1;
        pick_idx = IDXW'(i);
      end
    end
  end

  assign pick_oh = NIRQ'(1) << pick_idx;
  assign capture = found & ~ack_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q     <= '0;
      ack_valid  <= 1'b0;
      ack_onehot <= '0;
      ack_idx    <= '0;
    end else begin
      flag_q <= (flag_q & ~(capture ? pick_oh : '0)) | irq_raise;
      if (capture) begin
        ack_valid  <= 1'b1;
        ack_onehot <= pick_oh;
        ack_idx    <= pick_idx;
      end else if (ack_ready) begin
        ack_valid <= 1'b0;
      end
    end
  end

  // R12
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> ack_valid && $stable(ack_idx) && $stable(ack_onehot));
  // R11
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $onehot(ack_onehot));
  // R9
  double_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_valid && intm && dbgm) |=> !ack_valid);
endmodule

// File: rtl/rtdbg_ctrl.sv
module rtdbg_ctrl
  import rtdbg_pkg::*;
#(
  parameter int NIRQ = 16,
  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swbp_i,
  input  logic            wp_hit_i,
  input  logic            host_halt_i,
  input  logic            host_run_i,
  input  logic            host_step_i,
  input  logic            instr_done_i,
  input  logic            intm_i,
  input  logic            dbgm_i,
  input  logic [NIRQ-1:0] ier_i,
  input  logic [NIRQ-1:0] dbgier_i,
  input  logic [NIRQ-1:0] irq_raise_i,
  input  logic            dbg_acc_req_i,
  output logic            dbg_acc_gnt_o,
  output logic [1:0]      state_o,
  output logic            halt_o,
  output logic            ack_valid_o,
  input  logic            ack_ready_i,
  output logic [NIRQ-1:0] ack_onehot_o,
  output logic [IDXW-1:0] ack_idx_o
);
  dbg_state_e state_q;
  logic       enter_halt;
  logic       pend_q;

  rtdbg_halt_pend u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_run     (state_q == ST_RUN),
    .swbp       (swbp_i),
    .wp_hit     (wp_hit_i),
    .host_halt  (host_halt_i),
    .dbgm       (dbgm_i),
    .enter_halt (enter_halt),
    .pend_q     (pend_q)
  );

  rtdbg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_halt (enter_halt),
    .host_run   (host_run_i),
    .host_step  (host_step_i),
    .instr_done (instr_done_i),
    .state_q    (state_q)
  );

  rtdbg_irq_arb #(.NIRQ(NIRQ)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .halted     (state_q == ST_HALT),
    .intm       (intm_i),
    .dbgm       (dbgm_i),
    .ier        (ier_i),
    .dbgier     (dbgier_i),
    .irq_raise  (irq_raise_i),
    .ack_ready  (ack_ready_i),
    .ack_valid  (ack_valid_o),
    .ack_onehot (ack_onehot_o),
    .ack_idx    (ack_idx_o)
  );

  assign state_o       = state_q;
  assign halt_o        = (state_q == ST_HALT);
  assign dbg_acc_gnt_o = dbg_acc_req_i & ~dbgm_i;

  // R3
  swbp_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && swbp_i) |=> halt_o);
  // R4
  dbgm_holds_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && dbgm_i && !swbp_i) |=> state_o == 2'd0);
  // R4
  pend_idle_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !dbgm_i && pend_q) |=> halt_o);
endmodule

// File: tb/rtdbg_ctrl_bench.sv
module rtdbg_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 16;
  localparam int IDXW = $clog2(NIRQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swbp = 0, wp = 0, hhalt = 0, hrun = 0, hstep = 0, idone = 0;
  logic intm = 0, dbgm = 0, areq = 0, ardy = 0;
  logic [NIRQ-1:0] ier = '1, dbgier = '0, raise = '0;
  logic agnt, halt, avalid;
  logic [1:0] state;
  logic [NIRQ-1:0] aoh;
  logic [IDXW-1:0] aidx;

  int checks = 0;
  int fails = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtdbg_ctrl #(.NIRQ(NIRQ)) u_rtdbg_ctrl (
    .clk(clk), .rst_n(rst_n), .swbp_i(swbp), .wp_hit_i(wp),
    .host_halt_i(hhalt), .host_run_i(hrun), .host_step_i(hstep),
    .instr_done_i(idone), .intm_i(intm), .dbgm_i(dbgm), .ier_i(ier),
    .dbgier_i(dbgier), .irq_raise_i(raise), .dbg_acc_req_i(areq),
    .dbg_acc_gnt_o(agnt), .state_o(state), .halt_o(halt),
    .ack_valid_o(avalid), .ack_ready_i(ardy), .ack_onehot_o(aoh),
    .ack_idx_o(aidx)
  );

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(int idx);
    exp_q.push_back(idx);
  endtask

  // monitor: pops expected index on every completed handshake (R11, R12)
  always @(posedge clk) begin
    if (rst_n && avalid && ardy) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 actual=%0d expected=none", aidx);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (aidx !== IDXW'(e) || aoh !== (NIRQ'(1) << e)) begin
          fails++;
          $display("FAIL R11 actual=%0d expected=%0d", aidx, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 state", state, 0);
    chk("R1 halt", halt, 0);
    chk("R1 ack", avalid, 0);

    // R7 masked interrupts held, R11 priority, R12 back-pressure
    intm = 1; raise = (NIRQ'(1) << 5) | (NIRQ'(1) << 3);
    cyc(); raise = '0;
    cyc(3);
    chk("R7 masked", avalid, 0);
    push_exp(3); push_exp(5);
    intm = 0;
    cyc();
    chk("R11 lowest first", aidx, 3);
    chk("R7 taken after unmask", avalid, 1);
    cyc(2);
    chk("R12 held valid", avalid, 1);
    chk("R12 held idx", aidx, 3);
    ardy = 1;
    cyc(6);
    chk("R11 flags cleared", avalid, 0);
    chk("R11 all acked", exp_q.size(), 0);

    // R10 debug access
    areq = 1; #1;
    chk("R10 grant", agnt, 1);
    dbgm = 1; #1;
    chk("R10 refused", agnt, 0);
    areq = 0;

    // R4 deferred host halt
    hhalt = 1; cyc(); hhalt = 0;
    cyc(3);
    chk("R4 still run", state, 0);
    dbgm = 0;
    cyc();
    chk("R4 halt after unmask", state, 1);
    chk("R2 halt flag", halt, 1);
    hrun = 1; cyc(); hrun = 0;
    chk("R6 run cmd", state, 0);
    cyc(3);
    chk("R4 no rehalt", state, 0);

    // R2 watch hit
    wp = 1; cyc(); wp = 0;
    chk("R2 wp halt", state, 1);
    hrun = 1; hstep = 1; cyc(); hrun = 0; hstep = 0;
    chk("R6 run wins", state, 0);

    // R3 software breakpoint under debug mask
    dbgm = 1; swbp = 1; cyc(); swbp = 0;
    chk("R3 swbp halt", state, 1);
    dbgm = 0;

    // R8 halt-time interrupts ignore intm, need dbgier
    intm = 1; dbgier = NIRQ'(1) << 7;
    push_exp(7);
    raise = (NIRQ'(1) << 2) | (NIRQ'(1) << 7);
    cyc(); raise = '0;
    cyc(5);
    chk("R8 rt irq taken", exp_q.size(), 0);
    chk("R8 non-rt held", avalid, 0);

    // R6 step
    hstep = 1; cyc(); hstep = 0;
    chk("R6 step state", state, 2);
    cyc(2);
    chk("R7 step masked", avalid, 0);
    idone = 1; cyc(); idone = 0;
    chk("R6 back to halt", state, 1);
    hrun = 1; cyc(); hrun = 0;
    chk("R6 run", state, 0);

    // R9 both masks
    dbgm = 1; areq = 1;
    cyc(4);
    chk("R9 no irq", avalid, 0);
    chk("R9 no grant", agnt, 0);
    chk("R9 run kept", state, 0);
    areq = 0;
    push_exp(2);
    dbgm = 0; intm = 0;
    cyc(4);
    chk("R7 held irq taken", exp_q.size(), 0);

    // R5 shared halt entry
    swbp = 1; hhalt = 1; cyc(); swbp = 0; hhalt = 0;
    chk("R5 halt", state, 1);
    hrun = 1; cyc(); hrun = 0;
    cyc(4);
    chk("R5 no second halt", state, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule